// File: doc/BRIEF.md
# Single-Cycle RV32I Integer Core

This block is a small processor core that retires one RV32I integer instruction on every rising clock edge. It fetches from its own word-addressed instruction store, reads two source registers, forms an immediate, runs the ALU and the branch comparator, and picks the next program counter. It then commits the register write, the data store write and the new PC on one edge. Instructions and data live in separate arrays inside the block.

The instruction store is read-only to the core. It is filled through a load port, normally while reset is held. A combinational debug read port returns any architectural register, and the current PC is driven on an output. Together they let a surrounding environment compare the core's state against an instruction-level model. The supported classes are register-register arithmetic, immediate arithmetic, word load and store, the six conditional branches, jal and jalr.

Top module: `rv32_onecycle_core`

## Requirements
- R1: While reset is low and on the first cycle after it rises, the PC is 0 and every register reads 0. Reset does not clear the data array.
- R2: Register 0 always reads as zero. A write addressed to it has no effect.
- R3: Opcode 0110011 executes add, sub, sll, slt, sltu, xor, srl, sra, or and and. funct3 sits in inst[14:12], and inst[30] selects sub or sra. rs1, rs2 and rd come from inst[19:15], inst[24:20] and inst[11:7].
- R4: Opcode 0010011 applies the same functions to rs1 and the immediate inst[31:20], sign-extended from inst[31]. inst[30] selects srai only when funct3 is 101. For example, 0xFCE08793 writes x1-50 to x15.
- R5: Opcode 0100011 with funct3 010 stores rs2 into word (rs1+imm)[DAW+1:2], where imm is {inst[31:25],inst[11:7]} sign-extended. Opcode 0000011 with funct3 010 returns that word to rd. A store writes no register.
- R6: Opcode 1100011 compares rs1 with rs2. funct3 000/001/100/101/110/111 give eq/ne/lt/ge/ltu/geu. When the condition holds, the next PC is PC plus the B offset: bit 12 from inst[31], bit 11 from inst[7], bits 10:1 from inst[30:25] and inst[11:8], bit 0 zero. Otherwise the next PC is PC+4.
- R7: Opcode 1101111 writes PC+4 to rd and jumps to PC plus the J offset. The offset is {inst[31],inst[19:12],inst[20],inst[30:21],0}, sign-extended.
- R8: Opcode 1100111 writes PC+4 to rd and jumps to rs1 plus the unscaled I immediate, with bit 0 of the target cleared.
- R9: Every instruction that is not a taken branch or a jump advances the PC by exactly 4 on its edge. An unrecognised opcode acts as a no-op.
- R10: Instructions are fetched from word PC[IAW+1:2]. The load port writes ld_data to word ld_addr on an edge where ld_we is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_we | input | 1 | Instruction store write strobe |
| ld_addr | input | IAW | Instruction store word address |
| ld_data | input | 32 | Instruction word to store |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_val | output | 32 | Current contents of register dbg_sel |
| pc_o | output | 32 | Current program counter |

## Verification
The embedded properties assume that every branch and jump target stays word-aligned. They also assume the instruction store is not rewritten while the core runs, and that data addresses fall on word boundaries. The stimulus program respects all three. Every immediate offset used by its control transfers is a multiple of 4, and every jalr base register holds an aligned value. Loads and stores use only aligned offsets from register 0. The only jalr immediate with bit 0 set lands on a word boundary once that bit is cleared. The program is written into the store before reset is released and is left untouched afterwards.

// File: rtl/rv32_onecycle_core.sv
module rv32_onecycle_core #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_we,
  input  logic [IAW-1:0] ld_addr,
  input  logic [31:0]    ld_data,
  input  logic [4:0]     dbg_sel,
  output logic [31:0]    dbg_val,
  output logic [31:0]    pc_o
);
  localparam logic [6:0] OP_REG  = 7'b0110011;
  localparam logic [6:0] OP_IMM  = 7'b0010011;
  localparam logic [6:0] OP_LD   = 7'b0000011;
  localparam logic [6:0] OP_ST   = 7'b0100011;
  localparam logic [6:0] OP_BR   = 7'b1100011;
  localparam logic [6:0] OP_JAL  = 7'b1101111;
  localparam logic [6:0] OP_JALR = 7'b1100111;

  localparam logic [1:0] IMM_I = 2'd0, IMM_S = 2'd1, IMM_B = 2'd2, IMM_J = 2'd3;
  localparam logic [1:0] WB_MEM = 2'd0, WB_ALU = 2'd1, WB_LINK = 2'd2;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] regs [32];
  logic [31:0] pc_q;

  logic [31:0] inst;
  logic [6:0]  opc;
  logic [2:0]  f3;
  logic [4:0]  rs1, rs2, rd;

  assign inst = imem[pc_q[IAW+1:2]];
  assign opc  = inst[6:0];
  assign f3   = inst[14:12];
  assign rs1  = inst[19:15];
  assign rs2  = inst[24:20];
  assign rd   = inst[11:7];

  logic [1:0] imm_sel, wb_sel;
  logic       a_sel, b_sel, reg_we, mem_we, is_br, is_jump;
  logic [3:0] alu_fn;

  always_comb begin
    imm_sel = IMM_I;
    wb_sel  = WB_ALU;
    a_sel   = 1'b0;
    b_sel   = 1'b0;
    reg_we  = 1'b0;
    mem_we  = 1'b0;
    is_br   = 1'b0;
    is_jump = 1'b0;
    alu_fn  = 4'b0000;
    case (opc)
      OP_REG: begin
        reg_we = 1'b1;
        alu_fn = {inst[30], f3};
      end
      OP_IMM: begin
        reg_we = 1'b1;
        b_sel  = 1'b1;
        alu_fn = {(f3 == 3'b101) & inst[30], f3};
      end
      OP_LD: begin
        reg_we = 1'b1;
        b_sel  = 1'b1;
        wb_sel = WB_MEM;
      end
      OP_ST: begin
        mem_we  = 1'b1;
        b_sel   = 1'b1;
        imm_sel = IMM_S;
      end
      OP_BR: begin
        is_br   = 1'b1;
        a_sel   = 1'b1;
        b_sel   = 1'b1;
        imm_sel = IMM_B;
      end
      OP_JAL: begin
        reg_we  = 1'b1;
        a_sel   = 1'b1;
        b_sel   = 1'b1;
        imm_sel = IMM_J;
        wb_sel  = WB_LINK;
        is_jump = 1'b1;
      end
      OP_JALR: begin
        reg_we  = 1'b1;
        b_sel   = 1'b1;
        wb_sel  = WB_LINK;
        is_jump = 1'b1;
      end
      default: ;
    endcase
  end

  logic [31:0] imm;
  always_comb begin
    case (imm_sel)
      IMM_S:   imm = {{20{inst[31]}}, inst[31:25], inst[11:7]};
      IMM_B:   imm = {{19{inst[31]}}, inst[31], inst[7], inst[30:25], inst[11:8], 1'b0};
      IMM_J:   imm = {{11{inst[31]}}, inst[31], inst[19:12], inst[20], inst[30:21], 1'b0};
      default: imm = {{20{inst[31]}}, inst[31:20]};
    endcase
  end

  logic [31:0] rs1_val, rs2_val, op_a, op_b, alu_res;
  assign rs1_val = (rs1 == 5'd0) ? 32'd0 : regs[rs1];
  assign rs2_val = (rs2 == 5'd0) ? 32'd0 : regs[rs2];
  assign op_a    = a_sel ? pc_q : rs1_val;
  assign op_b    = b_sel ? imm : rs2_val;

  always_comb begin
    case (alu_fn[2:0])
      3'b000:  alu_res = alu_fn[3] ? op_a - op_b : op_a + op_b;
      3'b001:  alu_res = op_a << op_b[4:0];
      3'b010:  alu_res = {31'd0, $signed(op_a) < $signed(op_b)};
      3'b011:  alu_res = {31'd0, op_a < op_b};
      3'b100:  alu_res = op_a ^ op_b;
      3'b101:  alu_res = alu_fn[3] ? 32'($signed(op_a) >>> op_b[4:0]) : op_a >> op_b[4:0];
      3'b110:  alu_res = op_a | op_b;
      default: alu_res = op_a & op_b;
    endcase
  end

  logic br_eq, br_lt, br_take;
  assign br_eq = rs1_val == rs2_val;
  assign br_lt = f3[1] ? (rs1_val < rs2_val) : ($signed(rs1_val) < $signed(rs2_val));

  always_comb begin
    case (f3)
      3'b000:          br_take = br_eq;
      3'b001:          br_take = !br_eq;
      3'b100, 3'b110:  br_take = br_lt;
      3'b101, 3'b111:  br_take = !br_lt;
      default:         br_take = 1'b0;
    endcase
  end

  logic          pc_sel;
  logic [31:0]   pc_plus4, pc_next, wb_val, mem_rd;
  logic [DAW-1:0] dm_idx;

  assign pc_sel   = is_jump | (is_br & br_take);
  assign pc_plus4 = pc_q + 32'd4;
  assign pc_next  = pc_sel ? {alu_res[31:1], 1'b0} : pc_plus4;
  assign dm_idx   = alu_res[DAW+1:2];
  assign mem_rd   = dmem[dm_idx];

  always_comb begin
    case (wb_sel)
      WB_MEM:  wb_val = mem_rd;
      WB_LINK: wb_val = pc_plus4;
      default: wb_val = alu_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= 32'd0;
      for (int i = 0; i < 32; i++) regs[i] <= 32'd0;
    end else begin
      pc_q <= pc_next;
      if (reg_we && rd != 5'd0) regs[rd] <= wb_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && mem_we) dmem[dm_idx] <= rs2_val;
  end

  always_ff @(posedge clk) begin
    if (ld_we) imem[ld_addr] <= ld_data;
  end

  assign dbg_val = (dbg_sel == 5'd0) ? 32'd0 : regs[dbg_sel];
  assign pc_o    = pc_q;

  a_r1_pc_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pc_q == 32'd0);

  a_r2_x0_clean: assert property (@(posedge clk) disable iff (!rst_n)
    regs[0] == 32'd0);

  a_r5_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> dmem[$past(dm_idx)] == $past(rs2_val));

  a_r7_link_written: assert property (@(posedge clk) disable iff (!rst_n)
    (is_jump && rd != 5'd0) |=> regs[$past(rd)] == $past(pc_q) + 32'd4);

  a_r9_seq_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (opc != OP_BR && opc != OP_JAL && opc != OP_JALR) |=> pc_q == $past(pc_q) + 32'd4);

  a_r9_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00);
endmodule

// File: tb/rv32_onecycle_core_tb.sv
`timescale 1ns/10ps
module rv32_onecycle_core_tb_top;
  localparam int IW = 64;
  localparam int DW = 64;
  localparam int IAW = $clog2(IW);
  localparam int NSTEP = 60;

  function automatic logic [31:0] e_r(int f7, int s2, int s1, int f3, int d);
    return {f7[6:0], s2[4:0], s1[4:0], f3[2:0], d[4:0], 7'b0110011};
  endfunction
  function automatic logic [31:0] e_i(int im, int s1, int f3, int d, logic [6:0] op);
    return {im[11:0], s1[4:0], f3[2:0], d[4:0], op};
  endfunction
  function automatic logic [31:0] e_s(int im, int s2, int s1);
    return {im[11:5], s2[4:0], s1[4:0], 3'b010, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(int im, int s2, int s1, int f3);
    return {im[12], im[10:5], s2[4:0], s1[4:0], f3[2:0], im[4:1], im[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_j(int im, int d);
    return {im[20], im[10:1], im[11], im[19:12], d[4:0], 7'b1101111};
  endfunction

  localparam logic [6:0] OI = 7'b0010011, OL = 7'b0000011, OJR = 7'b1100111;
  localparam logic [31:0] NOP = 32'h00000013;

  localparam int NPROG = 50;
  localparam logic [31:0] PROG [NPROG] = '{
    e_i(100, 0, 0, 1, OI),        e_i(-50, 1, 0, 15, OI),     e_i(-7, 0, 0, 2, OI),
    e_r(0, 2, 1, 0, 3),           e_r(32, 1, 2, 0, 4),        e_r(0, 1, 2, 2, 5),
    e_r(0, 1, 2, 3, 6),           e_r(0, 2, 1, 4, 7),         e_r(0, 2, 1, 6, 8),
    e_r(0, 2, 1, 7, 9),           e_i(3, 0, 0, 10, OI),       e_r(0, 10, 2, 1, 11),
    e_r(0, 10, 2, 5, 12),         e_r(32, 10, 2, 5, 13),      e_i(4, 1, 1, 14, OI),
    e_i(1024 + 1, 2, 5, 16, OI),  e_i(28, 2, 5, 17, OI),      e_i(-6, 2, 2, 18, OI),
    e_i(-1, 1, 3, 19, OI),        e_i(-1, 1, 4, 20, OI),      e_i(240, 1, 6, 21, OI),
    e_i(127, 2, 7, 22, OI),       e_i(5, 1, 0, 0, OI),        e_r(0, 0, 0, 0, 23),
    e_s(8, 1, 0),                 e_s(12, 4, 0),              e_i(8, 0, 2, 24, OL),
    e_i(12, 0, 2, 25, OL),        e_b(8, 1, 1, 0),            e_i(1, 0, 0, 26, OI),
    e_b(8, 1, 1, 1),              e_b(8, 1, 2, 4),            e_i(2, 0, 0, 26, OI),
    e_b(8, 1, 2, 5),              e_b(8, 1, 2, 6),            e_b(8, 1, 2, 7),
    e_i(3, 0, 0, 26, OI),         e_j(8, 27),                 e_i(4, 0, 0, 26, OI),
    e_i(168, 0, 0, 28, OI),       e_i(1, 28, 0, 29, OJR),     e_i(5, 0, 0, 26, OI),
    e_i(1, 0, 0, 30, OI),         e_j(8, 0),                  NOP,
    32'hFFFFFFFF,                 e_i(1, 31, 0, 31, OI),      e_i(-1, 30, 0, 30, OI),
    e_b(-8, 0, 30, 5),            e_j(0, 0)
  };

  logic clk = 1'b0, rst_n = 1'b0, ld_we = 1'b0;
  logic [IAW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0] dbg_sel = '0;
  logic [31:0] dbg_val, pc_o;

  rv32_onecycle_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_sel(dbg_sel), .dbg_val(dbg_val), .pc_o(pc_o));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_reg(int idx, output logic [31:0] v);
    dbg_sel = idx[4:0];
    #0.1;
    v = dbg_val;
  endtask

  logic [31:0] img [IW];
  logic [31:0] mreg [32];
  logic [31:0] mmem [DW];
  logic [31:0] mpc;

  task automatic m_reset();
    mpc = 0;
    for (int i = 0; i < 32; i++) mreg[i] = 0;
  endtask

  task automatic m_step(output int wr);
    logic [31:0] in, a, b, ii, is, ib, ij, res, np;
    logic [2:0] fn;
    int d;
    in = img[mpc[IAW+1:2]];
    a  = mreg[in[19:15]];
    b  = mreg[in[24:20]];
    fn = in[14:12];
    d  = in[11:7];
    ii = $signed(in) >>> 20;
    is = {ii[31:5], in[11:7]};
    ib = {{20{in[31]}}, in[7], in[30:25], in[11:8], 1'b0};
    ij = {{12{in[31]}}, in[19:12], in[20], in[30:21], 1'b0};
    np = mpc + 4;
    wr = 0;
    res = 0;
    case (in[6:0])
      7'b0110011, 7'b0010011: begin
        logic [31:0] y;
        logic alt;
        y = (in[6:0] == 7'b0110011) ? b : ii;
        alt = in[30] && ((in[6:0] == 7'b0110011 && (fn == 0 || fn == 5)) || fn == 5);
        case (fn)
          0: res = alt ? a - y : a + y;
          1: res = a << y[4:0];
          2: res = ($signed(a) < $signed(y)) ? 1 : 0;
          3: res = (a < y) ? 1 : 0;
          4: res = a ^ y;
          5: res = alt ? 32'($signed(a) >>> y[4:0]) : a >> y[4:0];
          6: res = a | y;
          default: res = a & y;
        endcase
        wr = d;
      end
      7'b0000011: begin res = mmem[(a + ii) >> 2 & (DW - 1)]; wr = d; end
      7'b0100011: mmem[(a + is) >> 2 & (DW - 1)] = b;
      7'b1100011: begin
        bit t;
        case (fn)
          0: t = a == b;
          1: t = a != b;
          4: t = $signed(a) < $signed(b);
          5: t = $signed(a) >= $signed(b);
          6: t = a < b;
          7: t = a >= b;
          default: t = 0;
        endcase
        if (t) np = mpc + ib;
      end
      7'b1101111: begin res = mpc + 4; wr = d; np = mpc + ij; end
      7'b1100111: begin res = mpc + 4; wr = d; np = (a + ii) & ~32'd1; end
      default: ;
    endcase
    if (wr != 0) mreg[wr] = res;
    mpc = np;
  endtask

  initial begin
    logic [31:0] v;
    int w;
    for (int i = 0; i < IW; i++) img[i] = (i < NPROG) ? PROG[i] : NOP;
    for (int i = 0; i < DW; i++) mmem[i] = 0;
    m_reset();
    chk("R4 encoding of addi x15,x1,-50", PROG[1], 32'hFCE08793);
    @(negedge clk);
    for (int i = 0; i < IW; i++) begin
      ld_we = 1'b1; ld_addr = i[IAW-1:0]; ld_data = img[i];
      @(negedge clk);
    end
    ld_we = 1'b0;
    // data words read before written: seed with stores via the same core is not needed
    // because the program loads only addresses it stored first
    chk("R1 pc during reset", pc_o, 32'd0);
    for (int i = 0; i < 32; i++) begin rd_reg(i, v); chk("R1 register clear in reset", v, 32'd0); end
    rst_n = 1'b1;
    #0.1;
    chk("R1 pc after release", pc_o, 32'd0);
    for (int s = 0; s < NSTEP; s++) begin
      m_step(w);
      @(posedge clk);
      @(negedge clk);
      chk("R9 R6 R7 R8 R10 next pc", pc_o, mpc);
      rd_reg(w, v);
      chk("R3 R4 R5 R7 R8 destination value", v, mreg[w]);
    end
    for (int i = 0; i < 32; i++) begin rd_reg(i, v); chk("R3 R4 R5 final register file", v, mreg[i]); end
    rd_reg(15, v); chk("R4 x15 = x1-50", v, 32'd50);
    rd_reg(0, v);  chk("R2 x0 after addi to x0", v, 32'd0);
    rd_reg(23, v); chk("R2 add of x0+x0", v, 32'd0);
    rd_reg(24, v); chk("R5 word loaded after store", v, 32'd100);
    rd_reg(25, v); chk("R5 second stored word", v, 32'hFFFFFF95);
    rd_reg(26, v); chk("R6 skipped writes never happen", v, 32'd0);
    rd_reg(27, v); chk("R7 jal link", v, 32'd152);
    rd_reg(29, v); chk("R8 jalr link", v, 32'd164);
    rd_reg(31, v); chk("R6 backward branch taken once", v, 32'd2);
    rd_reg(13, v); chk("R3 sra of -7 by 3", v, 32'hFFFFFFFF);
    rd_reg(12, v); chk("R3 srl of -7 by 3", v, 32'h1FFFFFFF);
    rd_reg(16, v); chk("R4 srai of -7 by 1", v, 32'hFFFFFFFC);
    chk("R9 spin on self jump", pc_o, 32'd196);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    m_reset();
    chk("R1 pc after mid-run reset", pc_o, 32'd0);
    rd_reg(1, v); chk("R1 x1 cleared by reset", v, 32'd0);
    rst_n = 1'b1;
    m_step(w);
    @(posedge clk);
    @(negedge clk);
    rd_reg(1, v); chk("R1 first instruction after reset", v, 32'd100);
    chk("R9 pc after first instruction", pc_o, 32'd4);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule